// File: doc/BRIEF.md
# Interrupt Redirection Router

This block sits between a set of external interrupt request lines and several per-processor local interrupt receivers. It does not wire a request to a processor pin. It turns each request into a message on one shared bus. A message carries a vector, a priority, a destination processor and a delivery kind. A programmable table holds one entry per input. The entry gives the vector, the priority, the destination, a selection mode and a mask bit.

In fixed mode the message goes to the processor named in the entry. In lowest-priority mode the router looks at the task priority that every processor publishes. It picks the processor that currently runs the least important work. Processors can also send interrupts to one another. A processor writes a command naming a target and a vector, and the router forwards it over the same message bus. Only one message is formed per cycle. The message stays on the bus until the addressed receiver takes it.

Top module: `irq_router`

## Requirements
- R1: After reset no message is valid, and every table entry reads back as 16'h8000: masked, with all other fields zero.
- R2: An entry is written at its index and read back combinationally on `cfg_rdata`, with the field layout {mask[15], mode[14], dest[13:12], prio[11:8], vector[7:0]}. Indices 24 to 31 hold no entry: writes to them change nothing and reads from them return zero.
- R3: A rising edge on an unmasked input makes `msg_valid` high after exactly two clock edges, counted from the input going high. The message carries the entry's vector and priority. An input that stays high produces no further message.
- R4: In fixed mode (mode 0), the destination is the entry's dest field and the kind is 0.
- R5: In lowest-priority mode (mode 1), the kind is 1. The destination is the processor whose task priority is numerically lowest in the cycle the message is formed, with ties going to the lowest processor index. Processor i's priority sits at `tpr_flat[4*i+3:4*i]`.
- R6: An edge on a masked input is held pending and sends nothing. It is delivered once the entry is rewritten with the mask cleared.
- R7: Several edges on one input before its message is formed merge into a single message.
- R8: Writing a command sends a message of kind 2 with the written target and vector and priority 0. A command written while an earlier one is still waiting is ignored.
- R9: When sources wait together, the pending processor command goes first, then inputs in order of increasing index, one message per cycle.
- R10: A valid message keeps all its fields unchanged until `msg_accept` of its destination is high at a clock edge. Accept bits of other processors have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Table write strobe |
| cfg_addr | input | 5 | Table index for write and read |
| cfg_wdata | input | 16 | Entry value to write |
| cfg_rdata | output | 16 | Entry at `cfg_addr` |
| irq_in | input | 24 | External interrupt request lines |
| tpr_flat | input | 16 | Task priority of each processor, 4 bits each |
| ipi_we | input | 1 | Inter-processor command write strobe |
| ipi_target | input | 2 | Target processor of the command |
| ipi_vector | input | 8 | Vector of the command |
| msg_valid | output | 1 | Message on the bus is valid |
| msg_kind | output | 2 | 0 fixed, 1 lowest priority, 2 inter-processor |
| msg_dest | output | 2 | Destination processor |
| msg_vector | output | 8 | Interrupt vector |
| msg_prio | output | 4 | Entry priority (0 for commands) |
| msg_accept | input | 4 | Per-processor accept of the current message |

## Verification
The hardest cases to reach are merging and command dropping. Both need a source to stay pending while the output is busy, which a router with a fast receiver almost never shows. The bench gets there by holding back `msg_accept`, so that one message stays parked on the bus. While it waits, the bench pulses another input twice or writes two commands. Only after that does it release the parked message and count what follows. Lowest-priority selection gets constrained random task priorities and table entries, checked against a bench model, plus directed patterns with ties.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;
   typedef enum logic [1:0] {
      KIND_FIXED  = 2'd0,
      KIND_LOWEST = 2'd1,
      KIND_IPI    = 2'd2
   } msg_kind_e;
endpackage

// File: rtl/irq_rte_table.sv
module irq_rte_table #(
   parameter int N_IRQ = 24,
   parameter int ENT_W = 16,
   parameter int IDX_W = 5
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   we,
   input  logic [IDX_W-1:0]       addr,
   input  logic [ENT_W-1:0]       wdata,
   output logic [ENT_W-1:0]       rdata,
   output logic [N_IRQ*ENT_W-1:0] ent_flat
);
   // reset value: mask set, all other fields cleared
   localparam logic [ENT_W-1:0] RST_ENT = {1'b1, {(ENT_W-1){1'b0}}};

   logic [ENT_W-1:0] ent_q [N_IRQ];

   for (genvar g = 0; g < N_IRQ; g++) begin : g_ent
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            ent_q[g] <= RST_ENT;
         else if (we && (addr == IDX_W'(g)))
            ent_q[g] <= wdata;
      end
      assign ent_flat[g*ENT_W +: ENT_W] = ent_q[g];
   end

   // an index past the last entry reads zero
   always_comb begin
      rdata = '0;
      for (int i = 0; i < N_IRQ; i++)
         if (addr == IDX_W'(i)) rdata = ent_q[i];
   end
endmodule

// File: rtl/irq_edge_pending.sv
module irq_edge_pending #(
   parameter int N_IRQ = 24
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N_IRQ-1:0] irq_in,
   input  logic [N_IRQ-1:0] take,
   output logic [N_IRQ-1:0] pend
);
   logic [N_IRQ-1:0] prev_q;
   logic [N_IRQ-1:0] rise;

   assign rise = irq_in & ~prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q <= '0;
         pend   <= '0;
      end else begin
         prev_q <= irq_in;
         // a fresh edge outranks the clear of the message just formed
         pend   <= (pend & ~take) | rise;
      end
   end
endmodule

// File: rtl/irq_lowest_sel.sv
module irq_lowest_sel #(
   parameter int N_CPU = 4,
   parameter int TPR_W = 4,
   parameter int CPU_W = 2
) (
   input  logic [N_CPU*TPR_W-1:0] tpr_flat,
   output logic [CPU_W-1:0]       win
);
   logic [TPR_W-1:0] best_v;

   always_comb begin
      best_v = tpr_flat[TPR_W-1:0];
      win    = '0;
      // strict compare keeps the lower index on a tie
      for (int c = 1; c < N_CPU; c++) begin
         if (tpr_flat[c*TPR_W +: TPR_W] < best_v) begin
            best_v = tpr_flat[c*TPR_W +: TPR_W];
            win    = CPU_W'(c);
         end
      end
   end
endmodule

// File: rtl/irq_msg_arb.sv
module irq_msg_arb
   import irq_router_pkg::*;
#(
   parameter int N_IRQ  = 24,
   parameter int N_CPU  = 4,
   parameter int CPU_W  = 2,
   parameter int VEC_W  = 8,
   parameter int PRIO_W = 4,
   parameter int ENT_W  = 16,
   parameter int IDX_W  = 5
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   ipi_pend,
   input  logic [CPU_W-1:0]       ipi_dest,
   input  logic [VEC_W-1:0]       ipi_vec,
   input  logic [N_IRQ-1:0]       elig,
   input  logic [N_IRQ*ENT_W-1:0] ent_flat,
   input  logic [CPU_W-1:0]       lowest_idx,
   input  logic [N_CPU-1:0]       msg_accept,
   output logic                   take_ipi,
   output logic [N_IRQ-1:0]       take_irq,
   output logic                   slot_load,
   output logic                   msg_valid,
   output logic [1:0]             msg_kind,
   output logic [CPU_W-1:0]       msg_dest,
   output logic [VEC_W-1:0]       msg_vector,
   output logic [PRIO_W-1:0]      msg_prio
);
   localparam int PRIO_LSB = VEC_W;
   localparam int DEST_LSB = VEC_W + PRIO_W;
   localparam int MODE_BIT = DEST_LSB + CPU_W;

   logic             acc_hit;
   logic             slot_free;
   logic             pick_ok;
   logic [IDX_W-1:0] pick_idx;
   logic [ENT_W-1:0] sel_ent;
   msg_kind_e        nxt_kind;
   logic [CPU_W-1:0] nxt_dest;
   logic [VEC_W-1:0] nxt_vec;
   logic [PRIO_W-1:0] nxt_prio;

   always_comb begin
      acc_hit = 1'b0;
      for (int c = 0; c < N_CPU; c++)
         if (msg_dest == CPU_W'(c)) acc_hit = msg_valid & msg_accept[c];
   end

   assign slot_free = !msg_valid || acc_hit;

   // scan from the top so the lowest eligible index is kept
   always_comb begin
      pick_ok  = 1'b0;
      pick_idx = '0;
      for (int i = N_IRQ-1; i >= 0; i--) begin
         if (elig[i]) begin
            pick_ok  = 1'b1;
            pick_idx = IDX_W'(i);
         end
      end
   end

   assign sel_ent = ent_flat[pick_idx*ENT_W +: ENT_W];

   always_comb begin
      take_ipi = slot_free && ipi_pend;
      take_irq = '0;
      if (slot_free && !ipi_pend && pick_ok)
         take_irq[pick_idx] = 1'b1;
   end

   assign slot_load = take_ipi || (|take_irq);

   always_comb begin
      if (ipi_pend) begin
         nxt_kind = KIND_IPI;
         nxt_dest = ipi_dest;
         nxt_vec  = ipi_vec;
         nxt_prio = '0;
      end else begin
         nxt_kind = sel_ent[MODE_BIT] ? KIND_LOWEST : KIND_FIXED;
         nxt_dest = sel_ent[MODE_BIT] ? lowest_idx : sel_ent[DEST_LSB +: CPU_W];
         nxt_vec  = sel_ent[VEC_W-1:0];
         nxt_prio = sel_ent[PRIO_LSB +: PRIO_W];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         msg_valid  <= 1'b0;
         msg_kind   <= KIND_FIXED;
         msg_dest   <= '0;
         msg_vector <= '0;
         msg_prio   <= '0;
      end else if (slot_load) begin
         msg_valid  <= 1'b1;
         msg_kind   <= nxt_kind;
         msg_dest   <= nxt_dest;
         msg_vector <= nxt_vec;
         msg_prio   <= nxt_prio;
      end else if (acc_hit) begin
         msg_valid  <= 1'b0;
      end
   end
endmodule

// File: rtl/irq_router.sv
module irq_router #(
   parameter int N_IRQ  = 24,
   parameter int N_CPU  = 4,
   parameter int VEC_W  = 8,
   parameter int PRIO_W = 4,
   parameter int TPR_W  = 4,
   localparam int CPU_W = $clog2(N_CPU),
   localparam int IDX_W = $clog2(N_IRQ),
   localparam int ENT_W = 2 + CPU_W + PRIO_W + VEC_W
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   cfg_we,
   input  logic [IDX_W-1:0]       cfg_addr,
   input  logic [ENT_W-1:0]       cfg_wdata,
   output logic [ENT_W-1:0]       cfg_rdata,
   input  logic [N_IRQ-1:0]       irq_in,
   input  logic [N_CPU*TPR_W-1:0] tpr_flat,
   input  logic                   ipi_we,
   input  logic [CPU_W-1:0]       ipi_target,
   input  logic [VEC_W-1:0]       ipi_vector,
   output logic                   msg_valid,
   output logic [1:0]             msg_kind,
   output logic [CPU_W-1:0]       msg_dest,
   output logic [VEC_W-1:0]       msg_vector,
   output logic [PRIO_W-1:0]      msg_prio,
   input  logic [N_CPU-1:0]       msg_accept
);
   if (N_IRQ < 2)   begin : g_bad_irq  $error("N_IRQ must be at least 2");  end
   if (N_CPU < 2)   begin : g_bad_cpu  $error("N_CPU must be at least 2");  end
   if (VEC_W < 1)   begin : g_bad_vec  $error("VEC_W must be positive");    end
   if (TPR_W < 1)   begin : g_bad_tpr  $error("TPR_W must be positive");    end

   logic [N_IRQ*ENT_W-1:0] ent_flat;
   logic [N_IRQ-1:0]       pend;
   logic [N_IRQ-1:0]       elig;
   logic [N_IRQ-1:0]       take_irq;
   logic                   take_ipi;
   logic                   slot_load;
   logic [CPU_W-1:0]       lowest_idx;
   logic                   ipi_pend_q;
   logic [CPU_W-1:0]       ipi_dest_q;
   logic [VEC_W-1:0]       ipi_vec_q;
   logic                   tgt_ok;

   irq_rte_table #(.N_IRQ(N_IRQ), .ENT_W(ENT_W), .IDX_W(IDX_W)) u_table (
      .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr),
      .wdata(cfg_wdata), .rdata(cfg_rdata), .ent_flat(ent_flat)
   );

   irq_edge_pending #(.N_IRQ(N_IRQ)) u_edge (
      .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .take(take_irq), .pend(pend)
   );

   // the mask bit is the top bit of every entry
   for (genvar g = 0; g < N_IRQ; g++) begin : g_elig
      assign elig[g] = pend[g] & ~ent_flat[g*ENT_W + ENT_W - 1];
   end

   irq_lowest_sel #(.N_CPU(N_CPU), .TPR_W(TPR_W), .CPU_W(CPU_W)) u_lowest (
      .tpr_flat(tpr_flat), .win(lowest_idx)
   );

   // a target code past the last processor is only possible when N_CPU is not a power of two
   if (N_CPU == (1 << CPU_W)) begin : g_tgt_full
      assign tgt_ok = 1'b1;
   end else begin : g_tgt_part
      assign tgt_ok = (32'(ipi_target) < N_CPU);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ipi_pend_q <= 1'b0;
         ipi_dest_q <= '0;
         ipi_vec_q  <= '0;
      end else if (ipi_we && !ipi_pend_q && tgt_ok) begin
         ipi_pend_q <= 1'b1;
         ipi_dest_q <= ipi_target;
         ipi_vec_q  <= ipi_vector;
      end else if (take_ipi) begin
         ipi_pend_q <= 1'b0;
      end
   end

   irq_msg_arb #(
      .N_IRQ(N_IRQ), .N_CPU(N_CPU), .CPU_W(CPU_W), .VEC_W(VEC_W),
      .PRIO_W(PRIO_W), .ENT_W(ENT_W), .IDX_W(IDX_W)
   ) u_arb (
      .clk(clk), .rst_n(rst_n),
      .ipi_pend(ipi_pend_q), .ipi_dest(ipi_dest_q), .ipi_vec(ipi_vec_q),
      .elig(elig), .ent_flat(ent_flat), .lowest_idx(lowest_idx),
      .msg_accept(msg_accept), .take_ipi(take_ipi), .take_irq(take_irq),
      .slot_load(slot_load), .msg_valid(msg_valid), .msg_kind(msg_kind),
      .msg_dest(msg_dest), .msg_vector(msg_vector), .msg_prio(msg_prio)
   );
endmodule

// File: rtl/irq_router_chk.sv
module irq_router_chk #(
   parameter int N_CPU  = 4,
   parameter int CPU_W  = 2,
   parameter int VEC_W  = 8,
   parameter int PRIO_W = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              ipi_pend,
   input logic              msg_valid,
   input logic [1:0]        msg_kind,
   input logic [CPU_W-1:0]  msg_dest,
   input logic [VEC_W-1:0]  msg_vector,
   input logic [PRIO_W-1:0] msg_prio,
   input logic [N_CPU-1:0]  msg_accept
);
   logic own_acc;
   always_comb begin
      own_acc = 1'b0;
      for (int c = 0; c < N_CPU; c++)
         if (msg_dest == CPU_W'(c)) own_acc = msg_accept[c];
   end

   // R1: while reset is held no message appears
   a_r1_quiet_in_reset: assert property (@(posedge clk)
      !rst_n |=> !msg_valid);

   // R10: an unaccepted message stays valid
   a_r10_hold_valid: assert property (@(posedge clk) disable iff (!rst_n)
      msg_valid && !own_acc |=> msg_valid);

   // R10: an unaccepted message keeps its fields
   a_r10_hold_fields: assert property (@(posedge clk) disable iff (!rst_n)
      msg_valid && !own_acc |=> $stable(msg_vector) && $stable(msg_dest)
                               && $stable(msg_kind) && $stable(msg_prio));

   // R9: a waiting command takes the next free slot
   a_r9_ipi_first: assert property (@(posedge clk) disable iff (!rst_n)
      ipi_pend && (!msg_valid || own_acc) |=> msg_valid && msg_kind == 2'd2);
endmodule

bind irq_router irq_router_chk #(
   .N_CPU(N_CPU), .CPU_W(CPU_W), .VEC_W(VEC_W), .PRIO_W(PRIO_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .ipi_pend(ipi_pend_q), .msg_valid(msg_valid),
   .msg_kind(msg_kind), .msg_dest(msg_dest), .msg_vector(msg_vector),
   .msg_prio(msg_prio), .msg_accept(msg_accept)
);

// File: tb/irq_router_tb_top.sv
`timescale 1ns/1ps
module irq_router_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [4:0]  cfg_addr = '0;
   logic [15:0] cfg_wdata = '0;
   logic [15:0] cfg_rdata;
   logic [23:0] irq_in = '0;
   logic [15:0] tpr_flat = '0;
   logic        ipi_we = 1'b0;
   logic [1:0]  ipi_target = '0;
   logic [7:0]  ipi_vector = '0;
   logic        msg_valid;
   logic [1:0]  msg_kind;
   logic [1:0]  msg_dest;
   logic [7:0]  msg_vector;
   logic [3:0]  msg_prio;
   logic [3:0]  msg_accept = '0;

   int checks = 0;
   int failures = 0;
   bit done = 0;

   always #2.5 clk = ~clk;

   irq_router dut_i (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
      .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .irq_in(irq_in),
      .tpr_flat(tpr_flat), .ipi_we(ipi_we), .ipi_target(ipi_target),
      .ipi_vector(ipi_vector), .msg_valid(msg_valid), .msg_kind(msg_kind),
      .msg_dest(msg_dest), .msg_vector(msg_vector), .msg_prio(msg_prio),
      .msg_accept(msg_accept)
   );

   function automatic logic [15:0] ent(bit m, bit md, int d, int p, int v);
      return {m, md, 2'(d), 4'(p), 8'(v)};
   endfunction

   function automatic int model_lowest(logic [15:0] t);
      int best = 0;
      for (int c = 1; c < 4; c++)
         if (t[c*4 +: 4] < t[best*4 +: 4]) best = c;
      return best;
   endfunction

   task automatic chk(bit ok, string req, int act, int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   task automatic wr(int idx, logic [15:0] d);
      cfg_we = 1'b1; cfg_addr = 5'(idx); cfg_wdata = d;
      tick();
      cfg_we = 1'b0;
   endtask

   task automatic send_ipi(int t, int v);
      ipi_we = 1'b1; ipi_target = 2'(t); ipi_vector = 8'(v);
      tick();
      ipi_we = 1'b0;
   endtask

   task automatic pulse(int i);
      irq_in[i] = 1'b1;
      tick();
      irq_in[i] = 1'b0;
   endtask

   task automatic wait_valid();
      int n = 0;
      while (!msg_valid && n < 20) begin tick(); n++; end
   endtask

   task automatic expect_msg(string req, int kind, int dest, int vec, int prio);
      wait_valid();
      chk(msg_valid == 1'b1, {req, " valid"}, int'(msg_valid), 1);
      chk(int'(msg_kind) == kind, {req, " kind"}, int'(msg_kind), kind);
      chk(int'(msg_dest) == dest, {req, " dest"}, int'(msg_dest), dest);
      chk(int'(msg_vector) == vec, {req, " vector"}, int'(msg_vector), vec);
      if (prio >= 0) chk(int'(msg_prio) == prio, {req, " prio"}, int'(msg_prio), prio);
      msg_accept = 4'(1 << msg_dest);
      tick();
      msg_accept = '0;
   endtask

   task automatic expect_idle(string req, int n);
      repeat (n) tick();
      chk(msg_valid == 1'b0, {req, " idle"}, int'(msg_valid), 0);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++; failures++;
         $display("FAIL watchdog expired (all requirements) actual=hung expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd4242));
      repeat (3) tick();
      // R1 reset state
      chk(msg_valid == 1'b0, "R1 valid in reset", int'(msg_valid), 0);
      cfg_addr = 5'd0; #0.1;
      chk(cfg_rdata == 16'h8000, "R1 entry 0", int'(cfg_rdata), 16'h8000);
      cfg_addr = 5'd23; #0.1;
      chk(cfg_rdata == 16'h8000, "R1 entry 23", int'(cfg_rdata), 16'h8000);
      rst_n = 1'b1;
      tick();

      // R2 write and read back, out-of-range index
      wr(4, ent(0, 0, 3, 5, 8'hA4));
      cfg_addr = 5'd4; #0.1;
      chk(cfg_rdata == 16'h35A4, "R2 readback", int'(cfg_rdata), 16'h35A4);
      wr(30, 16'h1234);
      cfg_addr = 5'd30; #0.1;
      chk(cfg_rdata == 16'h0000, "R2 out of range", int'(cfg_rdata), 0);
      cfg_addr = 5'd4; #0.1;
      chk(cfg_rdata == 16'h35A4, "R2 neighbour unchanged", int'(cfg_rdata), 16'h35A4);

      // R3 latency, R4 fixed destination
      irq_in[4] = 1'b1;
      tick();
      chk(msg_valid == 1'b0, "R3 after one edge", int'(msg_valid), 0);
      tick();
      chk(msg_valid == 1'b1, "R3 after two edges", int'(msg_valid), 1);
      expect_msg("R4 fixed", 0, 3, 8'hA4, 5);
      expect_idle("R3 level held", 5);
      irq_in[4] = 1'b0;

      // R10 hold and foreign accept
      wr(6, ent(0, 0, 1, 2, 8'h66));
      pulse(6);
      wait_valid();
      msg_accept = 4'b0001;
      tick();
      msg_accept = '0;
      chk(msg_valid == 1'b1, "R10 foreign accept", int'(msg_valid), 1);
      chk(msg_vector == 8'h66, "R10 vector held", int'(msg_vector), 8'h66);
      expect_msg("R10 release", 0, 1, 8'h66, 2);

      // R7 merge while output is busy
      wr(2, ent(0, 0, 0, 1, 8'h22));
      wr(5, ent(0, 0, 2, 3, 8'h55));
      pulse(2);
      wait_valid();
      pulse(5); tick(); pulse(5); tick();
      chk(msg_vector == 8'h22, "R7 parked message", int'(msg_vector), 8'h22);
      expect_msg("R7 first", 0, 0, 8'h22, 1);
      expect_msg("R7 merged", 0, 2, 8'h55, 3);
      expect_idle("R7 single message", 4);

      // R6 mask holds pending
      wr(9, ent(1, 0, 1, 7, 8'h99));
      pulse(9);
      expect_idle("R6 masked", 6);
      wr(9, ent(0, 0, 1, 7, 8'h99));
      expect_msg("R6 unmasked", 0, 1, 8'h99, 7);

      // R8 command forward, second write while waiting dropped
      pulse(2);
      wait_valid();
      send_ipi(3, 8'hC3);
      send_ipi(1, 8'hD1);
      expect_msg("R8 parked irq", 0, 0, 8'h22, 1);
      expect_msg("R8 command", 2, 3, 8'hC3, 0);
      expect_idle("R8 dropped write", 4);

      // R9 ordering: command, then lower index
      wr(3, ent(0, 0, 0, 0, 8'h33));
      wr(7, ent(0, 0, 1, 0, 8'h77));
      irq_in[3] = 1'b1; irq_in[7] = 1'b1;
      ipi_we = 1'b1; ipi_target = 2'd2; ipi_vector = 8'hE2;
      tick();
      ipi_we = 1'b0; irq_in[3] = 1'b0; irq_in[7] = 1'b0;
      expect_msg("R9 command first", 2, 2, 8'hE2, 0);
      expect_msg("R9 index 3 second", 0, 0, 8'h33, 0);
      expect_msg("R9 index 7 third", 0, 1, 8'h77, 0);

      // R5 directed ties
      wr(10, ent(0, 1, 0, 4, 8'hAA));
      tpr_flat = {4'd2, 4'd1, 4'd1, 4'd5};
      pulse(10);
      expect_msg("R5 tie to lower index", 1, 1, 8'hAA, 4);
      tpr_flat = {4'd6, 4'd6, 4'd6, 4'd6};
      pulse(10);
      expect_msg("R5 all equal", 1, 0, 8'hAA, 4);

      // R4/R5 constrained random
      for (int k = 0; k < 40; k++) begin
         int idx;
         int md;
         int d;
         int p;
         int v;
         idx = int'($urandom_range(0, 23));
         md  = int'($urandom_range(0, 1));
         d   = int'($urandom_range(0, 3));
         p   = int'($urandom_range(0, 15));
         v   = int'($urandom_range(0, 255));
         tpr_flat = 16'($urandom);
         wr(idx, ent(0, md[0], d, p, v));
         pulse(idx);
         if (md == 1)
            expect_msg("R5 random", 1, model_lowest(tpr_flat), v, p);
         else
            expect_msg("R4 random", 0, d, v, p);
      end
      expect_idle("R3 random tail", 3);

      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule